// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank Row Tracking

This block sits at the front of a synthesizable SDRAM-style memory model. On each rising clock edge it samples the clock-enable, chip-select and the three command strobes, the bank select and the address bus. It turns the pin pattern into a single registered command pulse. The decoded pulse appears in the cycle after the sampling edge.

Alongside decoding, the block holds an open/closed flag and a latched row address for each internal bank. Any bank may be closed while the other banks keep their rows open, so an access in one bank can overlap a precharge in another. A read or write may also request that its bank close itself once the burst finishes. Commands that make no sense for the current bank state raise a one-cycle error pulse instead of a command pulse.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. Each decoded command pulse is high for exactly the one cycle that follows the edge that sampled it.
- R2: The command is decoded from {ras_n, cas_n, we_n} while cs_n is 0. 011 gives activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-set, 110 burst-stop and 111 no-op. At most one pulse output is high in any cycle.
- R3: While cs_n is 1 the pins are treated as a no-op. No pulse is raised, no error is raised and no row register changes.
- R4: An activate to a closed bank marks that bank open and stores addr[11:0] as its row.
- R5: A read or write to an open bank raises its pulse and loads addr[7:0] into col_q. col_q keeps its value at all other times.
- R6: An activate to an open bank, or a read or write to a closed bank, raises err_q for one cycle. Such a command raises no command pulse and changes no bank flag, no row and no column.
- R7: A precharge with addr[10]=0 closes only the bank named by ba. Every other bank keeps its open flag and its row.
- R8: A precharge with addr[10]=1 closes every bank, whatever ba holds.
- R9: A read or write with addr[10]=1 to an open bank closes that bank by itself. The bank's open flag falls after the BURST_LEN-th rising edge that follows the command edge (4 edges by default).
- R10: While cke is 0 the sampled command is ignored. No pulse or error is raised. The open flags, rows, column and any auto-close countdown all hold their values.
- R11: After reset every bank is closed, every row register is 0, col_q is 0, and all pulses and err_q are low.
- R12: Refresh, mode-set and burst-stop raise their own pulse and change no bank flag or row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column and auto-close/all-bank flag |
| act_stb | output | 1 | Activate decoded |
| rd_stb | output | 1 | Read decoded |
| wr_stb | output | 1 | Write decoded |
| pre_stb | output | 1 | Precharge decoded |
| ref_stb | output | 1 | Refresh decoded |
| mrs_stb | output | 1 | Mode-set decoded |
| bst_stb | output | 1 | Burst-stop decoded |
| col_q | output | 8 | Column of the last accepted read or write |
| open_q | output | 4 | Per-bank open flag, bit n is bank n |
| rows_q | output | 48 | Per-bank row, bank n in bits 12n+11 to 12n |
| err_q | output | 1 | One-cycle illegal-sequence pulse |

## Verification
Every pin pattern of the command table is applied. Each pattern is checked to raise its own pulse and no other, and this separates the eight encodings from one another. Activate, read and write are each tried against both open and closed banks, which separates legal accesses from the error cases. Precharge is tried with the all-bank flag both low and high, which shows whether a single-bank close leaves its neighbours alone. Auto-close is observed one edge before and at its deadline, once with the clock running and once with the clock enable dropped part-way through the countdown, so that an early close, a late close or a countdown that keeps running while frozen each show up.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [2:0] {
      C_NOP = 3'd0,
      C_ACT = 3'd1,
      C_RD  = 3'd2,
      C_WR  = 3'd3,
      C_PRE = 3'd4,
      C_REF = 3'd5,
      C_MRS = 3'd6,
      C_BST = 3'd7
   } cmd_t;

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
   import sdram_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_t cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = C_NOP;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            3'b000:  cmd = C_MRS;
            3'b110:  cmd = C_BST;
            default: cmd = C_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank #(
   parameter int ROW_W     = 12,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             do_open,
   input  logic             do_close,
   input  logic             do_ap,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q
);

   localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   logic ap_pend;
   logic ap_done;

   generate
      if (BURST_LEN == 1) begin : g_no_cnt
         assign ap_done = 1'b1;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (en) begin
               if (do_ap) begin
                  cnt <= CNT_W'(BURST_LEN - 1);
               end else if (ap_pend && cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end
            end
         end
         assign ap_done = (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         ap_pend <= 1'b0;
         row_q   <= '0;
      end else if (en) begin
         if (do_close) begin
            is_open <= 1'b0;
            ap_pend <= 1'b0;
         end else if (do_open) begin
            is_open <= 1'b1;
            row_q   <= row_in;
         end else if (do_ap) begin
            ap_pend <= 1'b1;
         end else if (ap_pend && ap_done) begin
            is_open <= 1'b0;
            ap_pend <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_trk_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            ba,
   input  logic [ROW_W-1:0]           addr,
   output logic                       act_stb,
   output logic                       rd_stb,
   output logic                       wr_stb,
   output logic                       pre_stb,
   output logic                       ref_stb,
   output logic                       mrs_stb,
   output logic                       bst_stb,
   output logic [COL_W-1:0]           col_q,
   output logic [NUM_BANKS-1:0]       open_q,
   output logic [NUM_BANKS*ROW_W-1:0] rows_q,
   output logic                       err_q
);

   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (COL_W > ROW_W) begin : g_bad_col
      $error("COL_W must not exceed ROW_W");
   end
   if (AP_BIT >= ROW_W || AP_BIT < COL_W) begin : g_bad_ap
      $error("AP_BIT must lie above the column field inside the address");
   end
   if (BURST_LEN < 1) begin : g_bad_bl
      $error("BURST_LEN must be at least 1");
   end

   cmd_t cmd;
   logic tgt_open;
   logic is_acc;
   logic illegal;
   logic flag_hi;

   sdram_trk_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign tgt_open = open_q[ba];
   assign is_acc   = (cmd == C_RD) || (cmd == C_WR);
   assign flag_hi  = addr[AP_BIT];
   assign illegal  = ((cmd == C_ACT) && tgt_open) || (is_acc && !tgt_open);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (ba == BA_W'(b));

      sdram_trk_bank #(
         .ROW_W     (ROW_W),
         .BURST_LEN (BURST_LEN)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (cke),
         .do_open  ((cmd == C_ACT) && sel && !open_q[b]),
         .do_close ((cmd == C_PRE) && (sel || flag_hi)),
         .do_ap    (is_acc && sel && open_q[b] && flag_hi),
         .row_in   (addr),
         .is_open  (open_q[b]),
         .row_q    (rows_q[b*ROW_W +: ROW_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_stb <= 1'b0;
         rd_stb  <= 1'b0;
         wr_stb  <= 1'b0;
         pre_stb <= 1'b0;
         ref_stb <= 1'b0;
         mrs_stb <= 1'b0;
         bst_stb <= 1'b0;
         err_q   <= 1'b0;
         col_q   <= '0;
      end else begin
         act_stb <= cke && !illegal && (cmd == C_ACT);
         rd_stb  <= cke && !illegal && (cmd == C_RD);
         wr_stb  <= cke && !illegal && (cmd == C_WR);
         pre_stb <= cke && (cmd == C_PRE);
         ref_stb <= cke && (cmd == C_REF);
         mrs_stb <= cke && (cmd == C_MRS);
         bst_stb <= cke && (cmd == C_BST);
         err_q   <= cke && illegal;
         if (cke && is_acc && !illegal) begin
            col_q <= addr[COL_W-1:0];
         end
      end
   end

endmodule

// File: rtl/sdram_trk_checker.sv
module sdram_trk_checker #(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int NUM_BANKS = 4,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cke,
   input logic                       cs_n,
   input logic                       ras_n,
   input logic                       cas_n,
   input logic                       we_n,
   input logic [BA_W-1:0]            ba,
   input logic [ROW_W-1:0]           addr,
   input logic                       act_stb,
   input logic                       rd_stb,
   input logic                       wr_stb,
   input logic                       pre_stb,
   input logic                       ref_stb,
   input logic                       mrs_stb,
   input logic                       bst_stb,
   input logic [COL_W-1:0]           col_q,
   input logic [NUM_BANKS-1:0]       open_q,
   input logic [NUM_BANKS*ROW_W-1:0] rows_q,
   input logic                       err_q
);

   logic pin_act, pin_rd, pin_pre;
   assign pin_act = cke && !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
   assign pin_rd  = cke && !cs_n && ({ras_n, cas_n, we_n} == 3'b101);
   assign pin_pre = cke && !cs_n && ({ras_n, cas_n, we_n} == 3'b010);

   p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb, err_q}));

   p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cs_n) |=> (!act_stb && !rd_stb && !wr_stb && !pre_stb && !err_q && $stable(rows_q)));

   p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act && !open_q[ba]) |=> (act_stb && open_q[$past(ba)]
         && rows_q[$past(ba)*ROW_W +: ROW_W] == $past(addr)));

   p_read_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_rd && open_q[ba]) |=> (rd_stb && col_q == $past(addr[COL_W-1:0])));

   p_act_open_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act && open_q[ba]) |=> (err_q && !act_stb && $stable(rows_q)));

   p_read_closed_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_rd && !open_q[ba]) |=> (err_q && !rd_stb && $stable(col_q)));

   p_pre_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pre && addr[AP_BIT]) |=> (open_q == '0));

   p_cke_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(open_q) && $stable(rows_q) && $stable(col_q) && !err_q && !act_stb));

endmodule

bind sdram_cmd_tracker sdram_trk_checker #(
   .ROW_W     (ROW_W),
   .COL_W     (COL_W),
   .NUM_BANKS (NUM_BANKS),
   .AP_BIT    (AP_BIT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cke     (cke),
   .cs_n    (cs_n),
   .ras_n   (ras_n),
   .cas_n   (cas_n),
   .we_n    (we_n),
   .ba      (ba),
   .addr    (addr),
   .act_stb (act_stb),
   .rd_stb  (rd_stb),
   .wr_stb  (wr_stb),
   .pre_stb (pre_stb),
   .ref_stb (ref_stb),
   .mrs_stb (mrs_stb),
   .bst_stb (bst_stb),
   .col_q   (col_q),
   .open_q  (open_q),
   .rows_q  (rows_q),
   .err_q   (err_q)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;

   localparam logic [2:0] E_ACT = 3'b011;
   localparam logic [2:0] E_RD  = 3'b101;
   localparam logic [2:0] E_WR  = 3'b100;
   localparam logic [2:0] E_PRE = 3'b010;
   localparam logic [2:0] E_REF = 3'b001;
   localparam logic [2:0] E_MRS = 3'b000;
   localparam logic [2:0] E_BST = 3'b110;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1;
   logic        ras_n = 1'b1;
   logic        cas_n = 1'b1;
   logic        we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic        act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb;
   logic [7:0]  col_q;
   logic [3:0]  open_q;
   logic [47:0] rows_q;
   logic        err_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sdram_cmd_tracker u_sdram_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
      .ref_stb(ref_stb), .mrs_stb(mrs_stb), .bst_stb(bst_stb),
      .col_q(col_q), .open_q(open_q), .rows_q(rows_q), .err_q(err_q)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pulses();
      return {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb, err_q};
   endfunction

   function automatic logic [11:0] row_of(input int b);
      return rows_q[b*12 +: 12];
   endfunction

   task automatic issue(input logic [2:0] enc, input logic [1:0] b, input logic [11:0] a);
      cs_n = 1'b0;
      {ras_n, cas_n, we_n} = enc;
      ba = b;
      addr = a;
      @(negedge clk);
      cs_n = 1'b1;
      {ras_n, cas_n, we_n} = 3'b111;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R11 open", open_q, 4'h0);
      check("R11 rows", rows_q, 48'h0);
      check("R11 pulses", pulses(), 8'h00);
      check("R11 col", col_q, 8'h00);
   endtask

   task automatic t_misc();
      issue(E_REF, 2'd0, 12'h000);
      check("R12 refresh pulse", pulses(), 8'b0000_1000);
      issue(E_MRS, 2'd1, 12'h033);
      check("R12 mode-set pulse", pulses(), 8'b0000_0100);
      issue(E_BST, 2'd2, 12'h000);
      check("R12 burst-stop pulse", pulses(), 8'b0000_0010);
      check("R12 banks unchanged", open_q, 4'h0);
      idle(1);
      check("R1 pulse lasts one cycle", pulses(), 8'h00);
   endtask

   task automatic t_act_rw();
      issue(E_ACT, 2'd1, 12'hABC);
      check("R4 act pulse", pulses(), 8'b1000_0000);
      check("R4 bank1 open", open_q, 4'b0010);
      check("R4 bank1 row", row_of(1), 12'hABC);
      issue(E_RD, 2'd1, 12'h05A);
      check("R5 read pulse", pulses(), 8'b0100_0000);
      check("R5 read col", col_q, 8'h5A);
      issue(E_WR, 2'd1, 12'h0FF);
      check("R5 write pulse", pulses(), 8'b0010_0000);
      check("R5 write col", col_q, 8'hFF);
      check("R5 bank stays open", open_q, 4'b0010);
   endtask

   task automatic t_errors();
      issue(E_ACT, 2'd1, 12'h123);
      check("R6 act to open bank err", pulses(), 8'b0000_0001);
      check("R6 row kept", row_of(1), 12'hABC);
      idle(1);
      check("R6 err one cycle", err_q, 1'b0);
      issue(E_RD, 2'd2, 12'h011);
      check("R6 read closed err", pulses(), 8'b0000_0001);
      check("R6 col kept", col_q, 8'hFF);
      issue(E_WR, 2'd3, 12'h022);
      check("R6 write closed err", pulses(), 8'b0000_0001);
      check("R6 flags kept", open_q, 4'b0010);
   endtask

   task automatic t_pre_single();
      issue(E_ACT, 2'd2, 12'h456);
      check("R7 two banks open", open_q, 4'b0110);
      issue(E_PRE, 2'd1, 12'h000);
      check("R7 pre pulse", pulses(), 8'b0001_0000);
      check("R7 only bank1 closed", open_q, 4'b0100);
      check("R7 bank2 row kept", row_of(2), 12'h456);
   endtask

   task automatic t_pre_all();
      issue(E_ACT, 2'd0, 12'h001);
      check("R8 setup", open_q, 4'b0101);
      issue(E_PRE, 2'd3, 12'h400);
      check("R8 all closed", open_q, 4'h0);
   endtask

   task automatic t_autopre();
      issue(E_ACT, 2'd3, 12'h777);
      issue(E_RD, 2'd3, 12'h410);
      check("R9 read pulse", rd_stb, 1'b1);
      check("R9 col", col_q, 8'h10);
      idle(3);
      check("R9 open before deadline", open_q, 4'b1000);
      idle(1);
      check("R9 closed at deadline", open_q, 4'b0000);
   endtask

   task automatic t_cke();
      issue(E_ACT, 2'd0, 12'h0AA);
      issue(E_WR, 2'd0, 12'h420);
      idle(1);
      cke = 1'b0;
      issue(E_ACT, 2'd1, 12'h333);
      check("R10 no pulse", pulses(), 8'h00);
      check("R10 act ignored", open_q, 4'b0001);
      issue(E_RD, 2'd2, 12'h099);
      check("R10 no err", err_q, 1'b0);
      check("R10 col held", col_q, 8'h20);
      idle(4);
      check("R10 countdown frozen", open_q, 4'b0001);
      cke = 1'b1;
      idle(2);
      check("R10 resumes open", open_q, 4'b0001);
      idle(1);
      check("R10 resumes close", open_q, 4'b0000);
      check("R10 row1 held", row_of(1), 12'hABC);
   endtask

   task automatic t_deselect();
      cs_n = 1'b1;
      {ras_n, cas_n, we_n} = E_ACT;
      ba = 2'd2;
      addr = 12'h5A5;
      @(negedge clk);
      {ras_n, cas_n, we_n} = 3'b111;
      check("R3 deselect no pulse", pulses(), 8'h00);
      check("R3 bank closed", open_q, 4'h0);
      check("R3 row kept", row_of(2), 12'h456);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_misc();
      t_act_rw();
      t_errors();
      t_pre_single();
      t_pre_all();
      t_autopre();
      t_cke();
      t_deselect();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule